// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the byte-wide, memory-mapped register front end of a serial port. A host bus writes and reads 8-bit registers at byte offsets. The block holds the port's global enable, receiver and transmitter enables, the character-format byte, a divider for the bit clock and a byte of FIFO settings. It drives all of these to the serial engine and FIFOs that sit beside it. It also gathers their status: FIFO fill state, a transmitter-idle indication and pulses for parity, framing and overrun errors. The host reads that status back through the register window.

Two interrupt sources are pending flags: transmit (bit 0) and receive (bit 1). The neighbouring FIFOs set them when their level thresholds are met. Software can also raise them on purpose by writing ones to a set register, for example to force a receive service when bytes sit below the FIFO threshold. Software clears them by writing ones to a clear register. One interrupt line combines the flags with per-source enable bits.

A self-clearing soft-reset bit flushes the FIFOs and wipes the pending flags and error bits. It keeps the programmed format, divider and FIFO settings. With the global enable off, the port is quiet. Register access remains possible while it is off.

Top module: `serial_regs_irq`

## Requirements
- R1: After reset every register reads 0, `irq`, `port_on`, `rx_on`, `tx_on` and `fifo_flush` are 0, and `rdata` is 0 while `rd_en` is low.
- R2: These registers read back what was written: offset 0x00 bit 0 (enable), 0x03 (8-bit format), 0x08/0x09 (divider low/high byte), 0x0B (FIFO settings) and 0x1E (interrupt enable, bits 1:0, upper bits read 0).
- R3: Reads of any offset outside the map (for example 0x05–0x07, 0x0C, 0x10) return 0. Writes there change no register.
- R4: Writing a 1 to bit 0 or bit 1 of offset 0x1D sets the transmit or receive pending flag, with no hardware event needed. Reading 0x1D returns the raw pending flags.
- R5: Writing a 1 to bit n of offset 0x1C clears pending flag n. A hardware event for that flag in the same cycle wins, and the flag stays set.
- R6: While the port is enabled, `tx_almost` high at a clock edge sets pending bit 0, and `rx_almost` high sets pending bit 1.
- R7: `irq` is high exactly when the port is enabled and some pending flag has its enable bit set. Offset 0x1F reads pending AND enable.
- R8: Control (0x01) bits 0 and 1 drive `rx_on` and `tx_on`, gated by the port enable. Writing bit 2 as 1 makes `fifo_flush` high for the following cycle only. Bit 2 always reads 0.
- R9: A soft reset clears the pending flags and the three error bits. It leaves the format, divider and FIFO-settings registers unchanged.
- R10: Line status (0x02): bit 0 parity, bit 1 framing and bit 2 overrun are set by one-cycle event pulses while enabled, and stay set until a soft reset. Bit 6 follows `tx_idle` live.
- R11: With the port enabled, a write to 0x04 gives a same-cycle `tx_push` with `tx_byte` = `wdata`. A read of 0x04 gives `rx_pop` and returns `rx_byte`. With the port disabled, neither strobe occurs.
- R12: FIFO status (0x0A) is read-only: bit 2 = `rx_empty`, bit 3 = `rx_almost`, bit 4 = `tx_full`, bit 7 = `tx_almost`, other bits 0.
- R13: With enable bit 0 cleared, `irq` is held low and hardware FIFO events and error pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when `rd_en` is low |
| port_on | output | 1 | Global enable state |
| rx_on | output | 1 | Receiver enable to serial engine |
| tx_on | output | 1 | Transmitter enable to serial engine |
| fifo_flush | output | 1 | One-cycle flush pulse after a soft reset |
| frame_cfg | output | 8 | Character format byte |
| baud_div | output | BAUD_W | Bit-clock divider |
| fifo_cfg | output | 8 | FIFO settings byte |
| tx_push | output | 1 | Push `tx_byte` into transmit FIFO |
| tx_byte | output | 8 | Byte for transmit FIFO |
| rx_pop | output | 1 | Pop receive FIFO |
| rx_byte | input | 8 | Head of receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_almost | input | 1 | Receive FIFO above threshold |
| tx_full | input | 1 | Transmit FIFO full |
| tx_almost | input | 1 | Transmit FIFO below threshold |
| tx_idle | input | 1 | Transmitter fully idle |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| err_overrun | input | 1 | Overrun error pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the behaviours that hold at all times. Set and clear writes must take effect on the next cycle, except where a same-cycle event wins a clear. A soft reset must clear the flags and error bits, flush the FIFOs for exactly one cycle and keep the divider. The interrupt line and the data strobes must stay quiet while the port is off, and the interrupt must stay low when no enabled flag is pending. Error pulses must stick. Only the bench's scenarios can show the register map as a whole: random read-back through the model, silence at unmapped offsets, the live and read-only FIFO status bits, the control read-back after a soft reset, and the retention of format and FIFO settings across it.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;

   // Byte offsets of the register window
   localparam logic [7:0] OFS_ENABLE  = 8'h00;
   localparam logic [7:0] OFS_CTRL    = 8'h01;
   localparam logic [7:0] OFS_LINE    = 8'h02;
   localparam logic [7:0] OFS_FORMAT  = 8'h03;
   localparam logic [7:0] OFS_DATA    = 8'h04;
   localparam logic [7:0] OFS_DIV_LO  = 8'h08;
   localparam logic [7:0] OFS_DIV_HI  = 8'h09;
   localparam logic [7:0] OFS_FSTAT   = 8'h0A;
   localparam logic [7:0] OFS_FSET    = 8'h0B;
   localparam logic [7:0] OFS_PCLR    = 8'h1C;
   localparam logic [7:0] OFS_PSET    = 8'h1D;
   localparam logic [7:0] OFS_IEN     = 8'h1E;
   localparam logic [7:0] OFS_ISTAT   = 8'h1F;

   // Interrupt source positions
   localparam int unsigned SRC_TX = 0;
   localparam int unsigned SRC_RX = 1;
   localparam int unsigned NSRC   = 2;

   // Control bits
   localparam int unsigned CB_RX   = 0;
   localparam int unsigned CB_TX   = 1;
   localparam int unsigned CB_SRST = 2;

   // Line status bits
   localparam int unsigned NERR    = 3;
   localparam int unsigned LB_IDLE = 6;

   // FIFO status bits
   localparam int unsigned FB_RXE = 2;
   localparam int unsigned FB_RXA = 3;
   localparam int unsigned FB_TXF = 4;
   localparam int unsigned FB_TXA = 7;

   typedef struct packed {
      logic enable;
      logic ctrl;
      logic line;
      logic format;
      logic data;
      logic div_lo;
      logic div_hi;
      logic fstat;
      logic fset;
      logic pclr;
      logic pset;
      logic ien;
      logic istat;
   } sel_t;

endpackage

// File: rtl/serial_addr_dec.sv
module serial_addr_dec
   import serial_reg_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic [AW-1:0] addr,
   output sel_t          sel
);

   function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
      return a == AW'(ofs);
   endfunction

   always_comb begin
      sel.enable = hit(addr, OFS_ENABLE);
      sel.ctrl   = hit(addr, OFS_CTRL);
      sel.line   = hit(addr, OFS_LINE);
      sel.format = hit(addr, OFS_FORMAT);
      sel.data   = hit(addr, OFS_DATA);
      sel.div_lo = hit(addr, OFS_DIV_LO);
      sel.div_hi = hit(addr, OFS_DIV_HI);
      sel.fstat  = hit(addr, OFS_FSTAT);
      sel.fset   = hit(addr, OFS_FSET);
      sel.pclr   = hit(addr, OFS_PCLR);
      sel.pset   = hit(addr, OFS_PSET);
      sel.ien    = hit(addr, OFS_IEN);
      sel.istat  = hit(addr, OFS_ISTAT);
   end

endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
   import serial_reg_pkg::*;
#(
   parameter int unsigned BAUD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel_enable,
   input  logic              sel_ctrl,
   input  logic              sel_format,
   input  logic              sel_div_lo,
   input  logic              sel_div_hi,
   input  logic              sel_fset,
   input  logic [7:0]        wdata,
   output logic              port_en,
   output logic              ctrl_rx,
   output logic              ctrl_tx,
   output logic              srst,
   output logic              flush,
   output logic [7:0]        format_q,
   output logic [BAUD_W-1:0] div_q,
   output logic [7:0]        fset_q
);

   localparam int unsigned HI_W = BAUD_W - 8;

   assign srst = wr & sel_ctrl & wdata[CB_SRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_en  <= 1'b0;
         ctrl_rx  <= 1'b0;
         ctrl_tx  <= 1'b0;
         flush    <= 1'b0;
         format_q <= '0;
         fset_q   <= '0;
      end else begin
         flush <= srst;
         if (wr && sel_enable) port_en <= wdata[0];
         if (wr && sel_ctrl) begin
            ctrl_rx <= wdata[CB_RX];
            ctrl_tx <= wdata[CB_TX];
         end
         if (wr && sel_format) format_q <= wdata;
         if (wr && sel_fset)   fset_q   <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else begin
         if (wr && sel_div_lo) div_q[7:0]        <= wdata;
         if (wr && sel_div_hi) div_q[BAUD_W-1:8] <= wdata[HI_W-1:0];
      end
   end

endmodule

// File: rtl/serial_irq_unit.sv
module serial_irq_unit
   import serial_reg_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic            sel_pclr,
   input  logic            sel_pset,
   input  logic            sel_ien,
   input  logic [NSRC-1:0] wbits,
   input  logic [NSRC-1:0] hw_evt,
   input  logic            port_en,
   input  logic            srst,
   output logic [NSRC-1:0] pend,
   output logic [NSRC-1:0] ien,
   output logic            irq
);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic raise;
      logic drop;
      logic nxt;

      assign raise = (wr & sel_pset & wbits[i]) | (hw_evt[i] & port_en);
      assign drop  = wr & sel_pclr & wbits[i];

      if (SET_WINS) begin : g_setwin
         assign nxt = raise | (pend[i] & ~drop);
      end else begin : g_clrwin
         assign nxt = (raise | pend[i]) & ~drop;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    pend[i] <= 1'b0;
         else if (srst) pend[i] <= 1'b0;
         else           pend[i] <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ien <= '0;
      else if (wr && sel_ien)  ien <= wbits;
   end

   assign irq = port_en & (|(pend & ien));

endmodule

// File: rtl/serial_line_status.sv
module serial_line_status
   import serial_reg_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            port_en,
   input  logic            srst,
   input  logic [NERR-1:0] evt,
   input  logic            tx_idle,
   input  logic            rx_empty,
   input  logic            rx_almost,
   input  logic            tx_full,
   input  logic            tx_almost,
   output logic [NERR-1:0] errs,
   output logic [7:0]      line_val,
   output logic [7:0]      fstat_val
);

   for (genvar e = 0; e < NERR; e++) begin : g_err
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  errs[e] <= 1'b0;
         else if (srst)               errs[e] <= 1'b0;
         else if (evt[e] && port_en)  errs[e] <= 1'b1;
      end
   end

   always_comb begin
      line_val          = '0;
      line_val[NERR-1:0] = errs;
      line_val[LB_IDLE] = tx_idle;
      fstat_val         = '0;
      fstat_val[FB_RXE] = rx_empty;
      fstat_val[FB_RXA] = rx_almost;
      fstat_val[FB_TXF] = tx_full;
      fstat_val[FB_TXA] = tx_almost;
   end

endmodule

// File: rtl/serial_regs_irq.sv
module serial_regs_irq
   import serial_reg_pkg::*;
#(
   parameter int unsigned AW       = 8,
   parameter int unsigned BAUD_W   = 16,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [AW-1:0]     addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              port_on,
   output logic              rx_on,
   output logic              tx_on,
   output logic              fifo_flush,
   output logic [7:0]        frame_cfg,
   output logic [BAUD_W-1:0] baud_div,
   output logic [7:0]        fifo_cfg,
   output logic              tx_push,
   output logic [7:0]        tx_byte,
   output logic              rx_pop,
   input  logic [7:0]        rx_byte,
   input  logic              rx_empty,
   input  logic              rx_almost,
   input  logic              tx_full,
   input  logic              tx_almost,
   input  logic              tx_idle,
   input  logic              err_parity,
   input  logic              err_frame,
   input  logic              err_overrun,
   output logic              irq
);

   if (AW < 5) begin : g_bad_aw
      $error("serial_regs_irq: AW must be at least 5");
   end
   if (BAUD_W < 9 || BAUD_W > 16) begin : g_bad_baud
      $error("serial_regs_irq: BAUD_W must lie in 9..16");
   end

   sel_t            sel;
   logic            ctrl_rx;
   logic            ctrl_tx;
   logic            srst;
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] ien;
   logic [NSRC-1:0] hw_evt;
   logic [NERR-1:0] errs;
   logic [7:0]      line_val;
   logic [7:0]      fstat_val;
   logic [15:0]     div16;
   logic [7:0]      rd_mux;

   serial_addr_dec #(.AW(AW)) u_dec (
      .addr (addr),
      .sel  (sel)
   );

   serial_ctrl_regs #(.BAUD_W(BAUD_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr_en),
      .sel_enable (sel.enable),
      .sel_ctrl   (sel.ctrl),
      .sel_format (sel.format),
      .sel_div_lo (sel.div_lo),
      .sel_div_hi (sel.div_hi),
      .sel_fset   (sel.fset),
      .wdata      (wdata),
      .port_en    (port_on),
      .ctrl_rx    (ctrl_rx),
      .ctrl_tx    (ctrl_tx),
      .srst       (srst),
      .flush      (fifo_flush),
      .format_q   (frame_cfg),
      .div_q      (baud_div),
      .fset_q     (fifo_cfg)
   );

   always_comb begin
      hw_evt         = '0;
      hw_evt[SRC_TX] = tx_almost;
      hw_evt[SRC_RX] = rx_almost;
   end

   serial_irq_unit #(.SET_WINS(SET_WINS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_en),
      .sel_pclr (sel.pclr),
      .sel_pset (sel.pset),
      .sel_ien  (sel.ien),
      .wbits    (wdata[NSRC-1:0]),
      .hw_evt   (hw_evt),
      .port_en  (port_on),
      .srst     (srst),
      .pend     (pend),
      .ien      (ien),
      .irq      (irq)
   );

   serial_line_status u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_en   (port_on),
      .srst      (srst),
      .evt       ({err_overrun, err_frame, err_parity}),
      .tx_idle   (tx_idle),
      .rx_empty  (rx_empty),
      .rx_almost (rx_almost),
      .tx_full   (tx_full),
      .tx_almost (tx_almost),
      .errs      (errs),
      .line_val  (line_val),
      .fstat_val (fstat_val)
   );

   assign rx_on   = port_on & ctrl_rx;
   assign tx_on   = port_on & ctrl_tx;
   assign tx_push = wr_en & sel.data & port_on;
   assign rx_pop  = rd_en & sel.data & port_on;
   assign tx_byte = wdata;
   assign div16   = 16'(baud_div);

   always_comb begin
      rd_mux = '0;
      if (sel.enable)      rd_mux = {7'b0, port_on};
      else if (sel.ctrl)   rd_mux = {6'b0, ctrl_tx, ctrl_rx};
      else if (sel.line)   rd_mux = line_val;
      else if (sel.format) rd_mux = frame_cfg;
      else if (sel.data)   rd_mux = rx_byte;
      else if (sel.div_lo) rd_mux = div16[7:0];
      else if (sel.div_hi) rd_mux = div16[15:8];
      else if (sel.fstat)  rd_mux = fstat_val;
      else if (sel.fset)   rd_mux = fifo_cfg;
      else if (sel.pset)   rd_mux = 8'(pend);
      else if (sel.ien)    rd_mux = 8'(ien);
      else if (sel.istat)  rd_mux = 8'(pend & ien);
   end

   assign rdata = rd_en ? rd_mux : 8'h00;

endmodule

// File: rtl/serial_regs_irq_chk.sv
module serial_regs_irq_chk #(
   parameter int unsigned AW     = 8,
   parameter int unsigned BAUD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [AW-1:0]     addr,
   input logic [7:0]        wdata,
   input logic              port_on,
   input logic              fifo_flush,
   input logic [BAUD_W-1:0] baud_div,
   input logic              tx_push,
   input logic              rx_pop,
   input logic              tx_almost,
   input logic              err_parity,
   input logic [1:0]        pend,
   input logic [1:0]        ien,
   input logic [2:0]        errs,
   input logic              irq
);

   logic wr_ctrl_rst;
   logic wr_set;
   logic wr_clr;

   assign wr_ctrl_rst = wr_en && (addr == AW'(8'h01)) && wdata[2];
   assign wr_set      = wr_en && (addr == AW'(8'h1D));
   assign wr_clr      = wr_en && (addr == AW'(8'h1C));

   p_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && wdata[1]) |=> pend[1]);

   p_sw_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && wdata[0] && !(tx_almost && port_on)) |=> !pend[0]);

   p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ien) == 2'b00) |-> !irq);

   p_flush_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |-> $past(wr_ctrl_rst));

   p_srst_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl_rst |=> (pend == 2'b00 && errs == 3'b000 && fifo_flush));

   p_srst_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl_rst |=> $stable(baud_div));

   p_err_stick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_parity && port_on && !wr_ctrl_rst) |=> errs[0]);

   p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !port_on |-> (!tx_push && !rx_pop));

   p_irq_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !port_on |-> !irq);

endmodule

bind serial_regs_irq serial_regs_irq_chk #(.AW(AW), .BAUD_W(BAUD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .addr       (addr),
   .wdata      (wdata),
   .port_on    (port_on),
   .fifo_flush (fifo_flush),
   .baud_div   (baud_div),
   .tx_push    (tx_push),
   .rx_pop     (rx_pop),
   .tx_almost  (tx_almost),
   .err_parity (err_parity),
   .pend       (pend),
   .ien        (ien),
   .errs       (errs),
   .irq        (irq)
);

// File: tb/serial_regs_irq_test.sv
`timescale 1ns/1ps
module serial_regs_irq_test;

   localparam int unsigned AW     = 8;
   localparam int unsigned BAUD_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [AW-1:0]     addr = '0;
   logic [7:0]        wdata = '0;
   logic [7:0]        rdata;
   logic              port_on, rx_on, tx_on, fifo_flush;
   logic [7:0]        frame_cfg, fifo_cfg, tx_byte;
   logic [BAUD_W-1:0] baud_div;
   logic              tx_push, rx_pop, irq;
   logic [7:0]        rx_byte = '0;
   logic              rx_empty = 1'b0, rx_almost = 1'b0, tx_full = 1'b0;
   logic              tx_almost = 1'b0, tx_idle = 1'b0;
   logic              err_parity = 1'b0, err_frame = 1'b0, err_overrun = 1'b0;

   int unsigned n_run = 0;
   int unsigned n_fail = 0;

   // bench model
   logic [7:0] mdl [5];
   logic [1:0] m_pend;

   always #2 clk = ~clk;

   serial_regs_irq #(.AW(AW), .BAUD_W(BAUD_W)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .port_on(port_on), .rx_on(rx_on),
      .tx_on(tx_on), .fifo_flush(fifo_flush), .frame_cfg(frame_cfg),
      .baud_div(baud_div), .fifo_cfg(fifo_cfg), .tx_push(tx_push),
      .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte),
      .rx_empty(rx_empty), .rx_almost(rx_almost), .tx_full(tx_full),
      .tx_almost(tx_almost), .tx_idle(tx_idle), .err_parity(err_parity),
      .err_frame(err_frame), .err_overrun(err_overrun), .irq(irq)
   );

   function automatic logic [7:0] rw_ofs(input int idx);
      case (idx)
         0: return 8'h03;
         1: return 8'h08;
         2: return 8'h09;
         3: return 8'h0B;
         default: return 8'h1E;
      endcase
   endfunction

   function automatic logic [7:0] rw_mask(input int idx);
      return (idx == 4) ? 8'h03 : 8'hFF;
   endfunction

   function automatic logic [7:0] istat_of(input logic [1:0] p, input logic [7:0] e);
      return {6'b0, p & e[1:0]};
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      #1 d = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic pulse_evt(input int which);
      @(negedge clk);
      case (which)
         0: rx_almost = 1'b1;
         1: tx_almost = 1'b1;
         2: err_parity = 1'b1;
         default: err_overrun = 1'b1;
      endcase
      @(posedge clk); #1;
      rx_almost = 1'b0; tx_almost = 1'b0; err_parity = 1'b0; err_overrun = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] rv;
      logic [7:0] d;
      int unsigned seed;
      seed = $urandom(32'd90210);
      for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
      m_pend = 2'b00;

      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(irq, 0, "R1 irq after reset");
      chk({port_on, rx_on, tx_on, fifo_flush}, 0, "R1 enables after reset");
      chk(rdata, 0, "R1 rdata idle");
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         bus_rd(rw_ofs(i), rv);
         chk(rv, 0, "R1 register reset value");
      end

      // R2 enable readback
      bus_wr(8'h00, 8'hFF);
      bus_rd(8'h00, rv);
      chk(rv, 8'h01, "R2 enable readback");
      chk(port_on, 1, "R13 port on");

      // R2 random read/write against model
      for (int k = 0; k < 40; k++) begin
         int wi, ri;
         wi = $urandom_range(4, 0);
         d  = 8'($urandom);
         bus_wr(rw_ofs(wi), d);
         mdl[wi] = d & rw_mask(wi);
         ri = $urandom_range(4, 0);
         bus_rd(rw_ofs(ri), rv);
         chk(rv, mdl[ri], "R2 random readback");
      end
      chk(frame_cfg, mdl[0], "R2 format output");
      chk(baud_div, {mdl[2], mdl[1]}, "R2 divider output");

      // R3 unmapped offsets
      begin
         logic [7:0] holes [5] = '{8'h05, 8'h06, 8'h07, 8'h0C, 8'h10};
         for (int h = 0; h < 5; h++) begin
            bus_wr(holes[h], 8'($urandom));
            bus_rd(holes[h], rv);
            chk(rv, 0, "R3 unmapped read");
         end
         bus_rd(8'h1C, rv);
         chk(rv, 0, "R3 clear register reads zero");
      end
      for (int i = 0; i < 5; i++) begin
         bus_rd(rw_ofs(i), rv);
         chk(rv, mdl[i], "R3 registers untouched by unmapped writes");
      end

      // R4 R5 R7 random set/clear
      for (int k = 0; k < 30; k++) begin
         logic [1:0] b;
         b = 2'($urandom);
         if ($urandom_range(1, 0) == 1) begin
            bus_wr(8'h1D, {6'($urandom), b});
            m_pend = m_pend | b;
         end else begin
            bus_wr(8'h1C, {6'($urandom), b});
            m_pend = m_pend & ~b;
         end
         if ($urandom_range(3, 0) == 0) begin
            d = 8'($urandom);
            bus_wr(8'h1E, d);
            mdl[4] = d & 8'h03;
         end
         bus_rd(8'h1D, rv);
         chk(rv, {6'b0, m_pend}, "R4 R5 raw pending");
         bus_rd(8'h1F, rv);
         chk(rv, istat_of(m_pend, mdl[4]), "R7 masked status");
         chk(irq, |istat_of(m_pend, mdl[4]), "R7 irq line");
      end

      // R6 hardware events
      bus_wr(8'h1C, 8'h03);
      bus_wr(8'h1E, 8'h03);
      mdl[4] = 8'h03;
      pulse_evt(0);
      bus_rd(8'h1D, rv);
      chk(rv, 8'h02, "R6 rx threshold sets bit 1");
      pulse_evt(1);
      bus_rd(8'h1D, rv);
      chk(rv, 8'h03, "R6 tx threshold sets bit 0");
      // R5 event beats clear in same cycle
      @(negedge clk);
      rx_almost = 1'b1; wr_en = 1'b1; addr = AW'(8'h1C); wdata = 8'h03;
      @(posedge clk); #1;
      rx_almost = 1'b0; wr_en = 1'b0;
      bus_rd(8'h1D, rv);
      chk(rv, 8'h02, "R5 event wins over clear");
      chk(irq, 1, "R7 irq with rx pending");

      // R13 port off
      bus_wr(8'h00, 8'h00);
      chk(irq, 0, "R13 irq held low when off");
      bus_wr(8'h1C, 8'h03);
      pulse_evt(0);
      pulse_evt(1);
      pulse_evt(2);
      bus_rd(8'h1D, rv);
      chk(rv, 0, "R13 events ignored when off");
      bus_rd(8'h02, rv);
      chk(rv, 0, "R13 error pulse ignored when off");
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(8'h04); wdata = 8'h77;
      #1 chk(tx_push, 0, "R11 no push when off");
      @(posedge clk); #1 wr_en = 1'b0;
      bus_wr(8'h00, 8'h01);

      // R11 data strobes
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(8'h04); wdata = 8'hA5;
      #1 chk({tx_push, tx_byte}, {1'b1, 8'hA5}, "R11 push with byte");
      @(posedge clk); #1 wr_en = 1'b0;
      rx_byte = 8'h3C;
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(8'h04);
      #1 chk({rx_pop, rdata}, {1'b1, 8'h3C}, "R11 pop and read byte");
      @(posedge clk); #1 rd_en = 1'b0;

      // R8 control enables
      bus_wr(8'h01, 8'h03);
      chk({rx_on, tx_on}, 2'b11, "R8 rx/tx enables");
      bus_wr(8'h01, 8'h02);
      chk({rx_on, tx_on}, 2'b01, "R8 tx only");
      bus_wr(8'h01, 8'h03);

      // R10 line status
      pulse_evt(2);
      pulse_evt(3);
      bus_rd(8'h02, rv);
      chk(rv, 8'h05, "R10 sticky parity and overrun");
      tx_idle = 1'b1;
      bus_rd(8'h02, rv);
      chk(rv, 8'h45, "R10 idle bit live");

      // R12 FIFO status
      rx_empty = 1'b1; tx_full = 1'b1;
      bus_rd(8'h0A, rv);
      chk(rv, 8'h14, "R12 fifo status bits");
      bus_wr(8'h0A, 8'hFF);
      rx_empty = 1'b0; tx_full = 1'b0;
      bus_rd(8'h0A, rv);
      chk(rv, 8'h00, "R12 fifo status read-only");

      // R8 R9 soft reset
      bus_wr(8'h1D, 8'h03);
      bus_wr(8'h01, 8'h07);
      chk(fifo_flush, 1, "R8 flush pulse");
      @(posedge clk); #1;
      chk(fifo_flush, 0, "R8 flush one cycle");
      bus_rd(8'h01, rv);
      chk(rv, 8'h03, "R8 reset bit reads zero");
      bus_rd(8'h1D, rv);
      chk(rv, 0, "R9 pending cleared");
      bus_rd(8'h02, rv);
      chk(rv, 8'h40, "R9 errors cleared");
      for (int i = 0; i < 4; i++) begin
         bus_rd(rw_ofs(i), rv);
         chk(rv, mdl[i], "R9 settings kept");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule